// File: doc/BRIEF.md
# Multi-Rate Timer Flag and Interrupt Timebase

This block turns a 4.5 MHz reference clock into the periodic timing events a small controller core needs. A sticky timer flag rises each time its selected interval expires and is consumed by a test-and-clear strobe. A timer interrupt tick runs at its own, separately chosen interval. An instruction-cycle strobe marks the core's cycle boundary for one of three cycle-time options.

The interrupt request output carries exactly one source at a time: a falling edge on an external pin (gated by its own enable), the timer tick, or a serial-transfer-done pulse. Each divider restarts from zero whenever its period code changes, so software gets a clean full interval after a reprogram. Interval lengths are given in reference clocks through two parameters. `BASE_DIV` is the number of clocks per 20 µs; its default of 90 gives 4.5 MHz. `CYC_UNIT` is the shortest cycle in clocks, 12 by default.

Top module: `mrt_timebase`

## Requirements
- R1: While reset is high and right after it is released, `tmr_flag`, `irq_req` and `cyc_stb` are 0.
- R2: The flag interval is L = BASE_DIV × {50, 250, 1250, 6250} clocks for `flag_sel` codes 0, 1, 2 and 3. At the default these are 1, 5, 25 and 125 ms. `tmr_flag` rises at the L-th rising edge after reset is released.
- R3: Once set, `tmr_flag` stays 1 until `flag_test` is high at a clock edge. At that edge it clears. If the interval expires at that same edge, the flag stays 1.
- R4: With `irq_src` = 2 (timer), `irq_req` is a one-cycle pulse every L = BASE_DIV × {4, 50, 100, 250} clocks for `irq_sel` codes 0 to 3. At the default these are 80 µs, 1, 2 and 5 ms.
- R5: With `irq_src` = 1 (external), `irq_req` pulses for one cycle after the clock edge that sees `ext_int_n` fall, but only if `ext_en` is 1. A rising edge, or a falling edge while `ext_en` is 0, gives no pulse.
- R6: With `irq_src` = 3 (serial), `irq_req` pulses for one cycle after an edge with `sio_done` high. Under any other source code, `sio_done` has no effect.
- R7: With `irq_src` = 0, `irq_req` stays 0 whatever the timer, pin or serial inputs do.
- R8: `cyc_stb` is a one-cycle pulse every CYC_UNIT × {1, 5, 15, 15} clocks for `cyc_sel` codes 0 to 3. At the default these are 12, 60 and 180 clocks, i.e. 2.67, 13.33 and 40 µs. The first pulse comes CYC_UNIT × mult clocks after reset.
- R9: A change of `flag_sel`, `irq_sel` or `cyc_sel` restarts that divider. The first clock edge that sees the new code zeroes the count and produces no event. The next event follows L edges later, where L is the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_sel | input | 2 | Timer flag interval code |
| irq_sel | input | 2 | Timer interrupt interval code |
| cyc_sel | input | 2 | Instruction cycle length code |
| flag_test | input | 1 | Test-and-clear strobe for the flag |
| irq_src | input | 2 | Interrupt source: 0 none, 1 external, 2 timer, 3 serial |
| ext_int_n | input | 1 | External interrupt pin, falling edge active |
| ext_en | input | 1 | Enable for the external interrupt |
| sio_done | input | 1 | Serial transfer done pulse |
| tmr_flag | output | 1 | Sticky timer flag |
| irq_req | output | 1 | One-cycle interrupt request |
| cyc_stb | output | 1 | One-cycle instruction cycle strobe |

## Verification
A count that is off by one, or a restart that fails to zero the count, moves the flag, the interrupt pulse or the cycle strobe by at least one clock. The bench catches this at the first event after a reset or code change, because it samples the exact edge before the event and the edge of the event. A wrong source gate or a missed edge detector shows as a missing or extra `irq_req` pulse within one cycle of the stimulus. A flag that clears on the wrong priority shows up the moment a test coincides with an expiry.

// File: rtl/mrt_pkg.sv
`timescale 1ns/1ps
package mrt_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_TMR  = 2'd2,
        SRC_SIO  = 2'd3
    } irq_src_e;

    typedef enum logic [0:0] {
        KIND_FLAG = 1'b0,
        KIND_IRQ  = 1'b1
    } tb_kind_e;

    typedef struct packed {
        logic ext_fall;
        logic tmr_tick;
        logic sio_evt;
    } irq_evt_t;

    // Interval in 20 us base units for each divider kind and code
    function automatic int unsigned base_units(tb_kind_e kind, logic [1:0] sel);
        int unsigned u;
        if (kind == KIND_FLAG) begin
            case (sel)
                2'd0:    u = 50;
                2'd1:    u = 250;
                2'd2:    u = 1250;
                default: u = 6250;
            endcase
        end else begin
            case (sel)
                2'd0:    u = 4;
                2'd1:    u = 50;
                2'd2:    u = 100;
                default: u = 250;
            endcase
        end
        return u;
    endfunction

    function automatic int unsigned max_units(tb_kind_e kind);
        return (kind == KIND_FLAG) ? 6250 : 250;
    endfunction

    // Multiple of the shortest instruction cycle
    function automatic int unsigned cyc_mult(logic [1:0] sel);
        int unsigned m;
        case (sel)
            2'd0:    m = 1;
            2'd1:    m = 5;
            default: m = 15;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mrt_period_div.sv
`timescale 1ns/1ps
module mrt_period_div
    import mrt_pkg::*;
#(
    parameter tb_kind_e    KIND     = KIND_FLAG,
    parameter int unsigned BASE_DIV = 90
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int unsigned MAXLEN = BASE_DIV * max_units(KIND);
    localparam int unsigned CW     = $clog2(MAXLEN + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [1:0]    sel_q;
    logic          chg;

    always_comb begin
        last = CW'(BASE_DIV * base_units(KIND, sel_q) - 1);
        chg  = (sel != sel_q);
        tick = !chg && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= sel;
        end else if (chg) begin
            cnt   <= '0;
            sel_q <= sel;
        end else if (cnt == last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= last) else $error("count beyond interval"); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel != sel_q) |=> (cnt == '0)) else $error("no restart"); // R9

endmodule

// File: rtl/mrt_cycle_strobe.sv
`timescale 1ns/1ps
module mrt_cycle_strobe
    import mrt_pkg::*;
#(
    parameter int unsigned CYC_UNIT = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       stb
);
    localparam int unsigned MAXLEN = CYC_UNIT * 15;
    localparam int unsigned CW     = $clog2(MAXLEN + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [1:0]    sel_q;
    logic          chg;
    logic          stb_q;

    always_comb begin
        last = CW'(CYC_UNIT * cyc_mult(sel_q) - 1);
        chg  = (sel != sel_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sel_q <= sel;
            stb_q <= 1'b0;
        end else if (chg) begin
            cnt   <= '0;
            sel_q <= sel;
            stb_q <= 1'b0;
        end else if (cnt == last) begin
            cnt   <= '0;
            stb_q <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            stb_q <= 1'b0;
        end
    end

    assign stb = stb_q;

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb_q |=> !stb_q) else $error("strobe longer than a cycle"); // R8

    AST_STB_AFTER_CHG: assert property (@(posedge clk) disable iff (rst)
        (sel != sel_q) |=> !stb_q) else $error("strobe on restart edge"); // R9

endmodule

// File: rtl/mrt_irq_select.sv
`timescale 1ns/1ps
module mrt_irq_select
    import mrt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_e src,
    input  logic     ext_int_n,
    input  logic     ext_en,
    input  logic     tmr_tick,
    input  logic     sio_done,
    output logic     irq
);
    logic     pin_q;
    logic     irq_q;
    irq_evt_t evt;
    logic     pick;

    always_comb begin
        evt.ext_fall = pin_q & ~ext_int_n & ext_en;
        evt.tmr_tick = tmr_tick;
        evt.sio_evt  = sio_done;
        case (src)
            SRC_EXT: pick = evt.ext_fall;
            SRC_TMR: pick = evt.tmr_tick;
            SRC_SIO: pick = evt.sio_evt;
            default: pick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b1;
            irq_q <= 1'b0;
        end else begin
            pin_q <= ext_int_n;
            irq_q <= pick;
        end
    end

    assign irq = irq_q;

    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_NONE) |=> !irq_q) else $error("request without source"); // R7

    AST_EXT_GATED: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_EXT && !ext_en) |=> !irq_q) else $error("external not gated"); // R5

endmodule

// File: rtl/mrt_timebase.sv
`timescale 1ns/1ps
module mrt_timebase
    import mrt_pkg::*;
#(
    parameter int unsigned BASE_DIV = 90,
    parameter int unsigned CYC_UNIT = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] flag_sel,
    input  logic [1:0] irq_sel,
    input  logic [1:0] cyc_sel,
    input  logic       flag_test,
    input  logic [1:0] irq_src,
    input  logic       ext_int_n,
    input  logic       ext_en,
    input  logic       sio_done,
    output logic       tmr_flag,
    output logic       irq_req,
    output logic       cyc_stb
);
    localparam int NDIV = 2;

    logic [1:0] div_sel  [NDIV];
    logic       div_tick [NDIV];
    logic       flag_q;

    assign div_sel[0] = flag_sel;
    assign div_sel[1] = irq_sel;

    for (genvar g = 0; g < NDIV; g++) begin : g_div
        mrt_period_div #(
            .KIND     (tb_kind_e'(g)),
            .BASE_DIV (BASE_DIV)
        ) u_div (
            .clk  (clk),
            .rst  (rst),
            .sel  (div_sel[g]),
            .tick (div_tick[g])
        );
    end

    // Sticky flag: expiry has priority over the test-and-clear strobe
    always_ff @(posedge clk) begin
        if (rst)              flag_q <= 1'b0;
        else if (div_tick[0]) flag_q <= 1'b1;
        else if (flag_test)   flag_q <= 1'b0;
    end

    assign tmr_flag = flag_q;

    mrt_irq_select u_irq (
        .clk       (clk),
        .rst       (rst),
        .src       (irq_src_e'(irq_src)),
        .ext_int_n (ext_int_n),
        .ext_en    (ext_en),
        .tmr_tick  (div_tick[1]),
        .sio_done  (sio_done),
        .irq       (irq_req)
    );

    mrt_cycle_strobe #(
        .CYC_UNIT (CYC_UNIT)
    ) u_cyc (
        .clk (clk),
        .rst (rst),
        .sel (cyc_sel),
        .stb (cyc_stb)
    );

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_test && !div_tick[0]) |=> !tmr_flag) else $error("flag not cleared"); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tmr_flag && !flag_test) |=> tmr_flag) else $error("flag dropped"); // R3

endmodule

// File: tb/mrt_timebase_test.sv
`timescale 1ns/1ps
module mrt_timebase_test;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 2;
    localparam int UNIT = 12;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] flag_sel, irq_sel, cyc_sel, irq_src;
    logic       flag_test, ext_int_n, ext_en, sio_done;
    logic       tmr_flag, irq_req, cyc_stb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mrt_timebase #(.BASE_DIV(BASE), .CYC_UNIT(UNIT)) uut (
        .clk(clk), .rst(rst), .flag_sel(flag_sel), .irq_sel(irq_sel),
        .cyc_sel(cyc_sel), .flag_test(flag_test), .irq_src(irq_src),
        .ext_int_n(ext_int_n), .ext_en(ext_en), .sio_done(sio_done),
        .tmr_flag(tmr_flag), .irq_req(irq_req), .cyc_stb(cyc_stb)
    );

    function automatic int flag_len(int c);
        case (c)
            0: return BASE * 50;
            1: return BASE * 250;
            2: return BASE * 1250;
            default: return BASE * 6250;
        endcase
    endfunction

    function automatic int irq_len(int c);
        case (c)
            0: return BASE * 4;
            1: return BASE * 50;
            2: return BASE * 100;
            default: return BASE * 250;
        endcase
    endfunction

    function automatic int cyc_len(int c);
        case (c)
            0: return UNIT;
            1: return UNIT * 5;
            default: return UNIT * 15;
        endcase
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Change flag interval together with a test strobe; check the restart timing
    task automatic flag_restart(input int c);
        int len;
        len = flag_len(c);
        flag_sel  = c[1:0];
        flag_test = 1'b1;
        step(1);
        flag_test = 1'b0;
        step(len - 1);
        check("R9 flag before first expiry", int'(tmr_flag), 0);
        step(1);
        check("R2 flag at first expiry", int'(tmr_flag), 1);
    endtask

    task automatic irq_restart(input int c);
        int len;
        len = irq_len(c);
        irq_sel = c[1:0];
        step(1);
        step(len - 1);
        check("R9 irq before first tick", int'(irq_req), 0);
        step(1);
        check("R4 irq at first tick", int'(irq_req), 1);
        step(1);
        check("R4 irq one-cycle pulse", int'(irq_req), 0);
        step(len - 2);
        check("R4 irq before second tick", int'(irq_req), 0);
        step(1);
        check("R4 irq at second tick", int'(irq_req), 1);
    endtask

    task automatic cyc_restart(input int c);
        int len;
        len = cyc_len(c);
        cyc_sel = c[1:0];
        step(1);
        step(len - 1);
        check("R9 strobe before first pulse", int'(cyc_stb), 0);
        step(1);
        check("R8 strobe at first pulse", int'(cyc_stb), 1);
        step(1);
        check("R8 strobe one-cycle pulse", int'(cyc_stb), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int cur;
        int hits;
        void'($urandom(32'd4711));
        rst = 1'b1;
        flag_sel = 2'd0; irq_sel = 2'd0; cyc_sel = 2'd0; irq_src = 2'd0;
        flag_test = 1'b0; ext_int_n = 1'b1; ext_en = 1'b0; sio_done = 1'b0;
        step(3);
        check("R1 flag in reset", int'(tmr_flag), 0);
        check("R1 irq in reset", int'(irq_req), 0);
        check("R1 strobe in reset", int'(cyc_stb), 0);
        rst = 1'b0;

        // Cycle strobe and flag from reset release (code 0)
        step(UNIT - 1);
        check("R8 strobe before first", int'(cyc_stb), 0);
        step(1);
        check("R8 strobe first after reset", int'(cyc_stb), 1);
        step(1);
        check("R8 strobe drops", int'(cyc_stb), 0);
        step(flag_len(0) - UNIT - 2);
        check("R2 flag before expiry", int'(tmr_flag), 0);
        step(1);
        check("R2 flag at expiry", int'(tmr_flag), 1);
        step(50);
        check("R3 flag sticky", int'(tmr_flag), 1);
        flag_test = 1'b1;
        step(1);
        flag_test = 1'b0;
        check("R3 flag cleared by test", int'(tmr_flag), 0);
        // now 151 edges since release; next expiry at edge 200
        step(48);
        check("R3 flag before second expiry", int'(tmr_flag), 0);
        flag_test = 1'b1;
        step(1);
        flag_test = 1'b0;
        check("R3 expiry beats clear", int'(tmr_flag), 1);

        // Flag restarts: directed then random codes
        flag_restart(1);
        cur = 1;
        for (int it = 0; it < 4; it++) begin
            int c;
            c = int'($urandom % 4);
            if (c == cur) c = (c + 1) % 4;
            flag_restart(c);
            cur = c;
        end

        // Timer interrupt source over every code
        irq_src = 2'd2;
        irq_restart(1);
        irq_restart(2);
        irq_restart(3);
        irq_restart(0);

        // No source: nothing passes
        irq_src = 2'd0;
        ext_en = 1'b1;
        hits = 0;
        for (int i = 0; i < 40; i++) begin
            ext_int_n = (i % 4 == 1) ? 1'b0 : 1'b1;
            sio_done  = (i % 5 == 2);
            step(1);
            if (irq_req) hits++;
        end
        sio_done = 1'b0; ext_int_n = 1'b1;
        check("R7 no request without source", hits, 0);

        // External pin source
        irq_src = 2'd1;
        ext_en = 1'b0;
        step(2);
        ext_int_n = 1'b0;
        step(1);
        check("R5 disabled falling edge ignored", int'(irq_req), 0);
        ext_int_n = 1'b1;
        step(1);
        sio_done = 1'b1;
        step(1);
        sio_done = 1'b0;
        check("R6 serial ignored under external source", int'(irq_req), 0);
        ext_en = 1'b1;
        ext_int_n = 1'b0;
        step(1);
        check("R5 enabled falling edge", int'(irq_req), 1);
        step(1);
        check("R5 pulse one cycle while pin low", int'(irq_req), 0);
        ext_int_n = 1'b1;
        step(1);
        check("R5 rising edge ignored", int'(irq_req), 0);

        // Serial source
        irq_src = 2'd3;
        ext_int_n = 1'b0;
        step(1);
        check("R6 pin fall ignored under serial source", int'(irq_req), 0);
        ext_int_n = 1'b1;
        sio_done = 1'b1;
        step(1);
        sio_done = 1'b0;
        check("R6 serial done request", int'(irq_req), 1);
        step(1);
        check("R6 serial pulse one cycle", int'(irq_req), 0);

        // Cycle strobe: each code, then random
        cyc_restart(1);
        cyc_restart(2);
        cyc_restart(3);
        cyc_restart(0);
        cur = 0;
        for (int it = 0; it < 6; it++) begin
            int c;
            c = int'($urandom % 4);
            if (c == cur) c = (c + 1) % 4;
            cyc_restart(c);
            cur = c;
        end

        done = 1;
        summary();
        $finish;
    end
endmodule